// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target-side protocol engine of a two-wire serial memory. It runs on a fast system clock and oversamples the clock line (SCL) and data line (SDA). Each line passes through a two-flop synchronizer and a three-sample majority filter before any edge is detected. The block drives SDA only through an open-drain pull-low output. It finds START and STOP conditions and shifts bytes in and out MSB first. It drives acknowledge bits and walks the host through byte write, page write, current-address read, random read and sequential read.

The device address byte carries a fixed nibble `1010` in bits 7..4. Bits 3..1 hold the upper memory address bits; how many of them are used depends on the memory size, set by `ADDR_W`. Bit 0 is the read/write select. A memory backend sits beside the block and keeps the address counter, the page rollover, the write timing and the storage array. The block gives it a word-address load, a write-byte strobe, a read request and a stop event. While the backend is busy with an internal write, `busy_in` makes the block refuse its device address, so the host can poll with acknowledges.

States:
- `ST_IDLE`: waits for a START.
- `ST_DEV`: shifts in the device address byte.
- `ST_DEV_ACK`: ninth clock after a matching device address.
- `ST_WADDR`: shifts in the word address byte.
- `ST_WADDR_ACK`: ninth clock after the word address.
- `ST_WDATA`: shifts in a write data byte.
- `ST_WDATA_ACK`: ninth clock after a write data byte.
- `ST_RDATA`: shifts a read byte out.
- `ST_RD_ACK`: samples the host's acknowledge bit.
- `ST_RD_NEXT`: the host has acknowledged; waits for the SCL fall.
- `ST_WAIT_STOP`: the host has declined more data; waits for a START or STOP.

Transitions:
- A STOP from any state goes to `ST_IDLE`. A START from any state goes to `ST_DEV`.
- `ST_DEV` goes to `ST_DEV_ACK` on a match and to `ST_IDLE` on a mismatch or when busy.
- `ST_DEV_ACK` goes to `ST_RDATA` for a read and to `ST_WADDR` for a write.
- `ST_WADDR` → `ST_WADDR_ACK` → `ST_WDATA`.
- `ST_WDATA` → `ST_WDATA_ACK` → `ST_WDATA`.
- `ST_RDATA` → `ST_RD_ACK`.
- `ST_RD_ACK` goes to `ST_RD_NEXT` on a host ACK (0) and to `ST_WAIT_STOP` on a NACK (1).
- `ST_RD_NEXT` → `ST_RDATA`.

Top module: `tw_mem_target`

## Requirements
- R1: A STOP (SDA rising while SCL is high) returns the block to idle from any state, releases SDA and pulses `stop_evt` for one cycle. A START (SDA falling while SCL is high) in any state, including part way through a byte, aborts the transfer and begins a new device address phase.
- R2: A device address byte whose bits 7..4 equal `1010` is acknowledged by holding `sda_drive_low` during the ninth clock. Any other byte is not acknowledged, and all further bytes are ignored (no acknowledge, no backend event) until the next START.
- R3: After the word address byte, the block acknowledges and pulses `addr_set` for one cycle. At the same time `word_addr` presents device-address bits 3..1 as its bits [10:8] (only the lowest ADDR_W-8 of them are kept) and the word address byte as bits [7:0].
- R4: Every data byte in a write is acknowledged. For each one `wr_strobe` pulses for one cycle with the byte on `wr_data`, for any number of bytes up to a STOP.
- R5: A read issues one `rd_req` pulse after the device address is acknowledged and one more after each host acknowledge. The `rd_data` value presented after each request is shifted out MSB first. Consecutive bytes follow the backend's counter, so a read with no word address continues from where the last access left off.
- R6: When the host answers a read byte with a 1 (NACK), the block releases SDA and issues no further `rd_req` until a new START.
- R7: A repeated START after the word address acknowledge starts a new device address phase. A read address then returns data from the word address just loaded (random read).
- R8: `sda_drive_low` changes only while the filtered SCL is low. The host therefore never sees the data line move during its SCL-high phase, apart from START and STOP.
- R9: While `busy_in` is 1, a device address byte with a matching nibble is not acknowledged. Once `busy_in` returns to 0 it is acknowledged again.
- R10: A pulse on SCL one system clock long is removed by the input filter and neither shifts a bit nor ends a byte.
- R11: After reset, SDA is released and none of `addr_set`, `wr_strobe`, `rd_req` and `stop_evt` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Two-wire clock line as seen at the pad |
| sda_in | input | 1 | Two-wire data line as seen at the pad (wired level) |
| busy_in | input | 1 | Backend internal write in progress; device address is refused |
| rd_data | input | 8 | Read byte from the backend, valid the cycle after `rd_req` |
| sda_drive_low | output | 1 | Pull the data line low (open-drain enable) |
| addr_set | output | 1 | One-cycle pulse: load `word_addr` into the backend counter |
| word_addr | output | ADDR_W | Word address assembled from device-address and word-address bytes |
| wr_strobe | output | 1 | One-cycle pulse: write `wr_data` at the backend counter |
| wr_data | output | 8 | Received write data byte |
| rd_req | output | 1 | One-cycle pulse: backend presents the next read byte |
| stop_evt | output | 1 | One-cycle pulse on every STOP condition |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the pull-low output only moves while the filtered clock is low;
- the address load and the write strobe always come together with an acknowledge being driven;
- no two backend events share a cycle;
- a STOP always leaves the line released;
- a busy backend never sees its device address acknowledged.

The rest can only be shown by the bench's host transactions:
- nibble mismatch followed by silence;
- page rollover and sequential wrap through the backend counter;
- the repeated-START random read;
- the read ending after a host NACK;
- the START that aborts a half-sent byte;
- rejection of a one-cycle SCL glitch.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
    localparam logic [3:0] DEV_NIBBLE = 4'b1010;
    localparam int         BYTE_BITS  = 8;
    localparam int         DEV_HI_W   = 3;
    localparam int         CNT_W      = $clog2(BYTE_BITS + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_RD_NEXT,
        ST_WAIT_STOP
    } tw_state_e;
endpackage

// File: rtl/tw_glitch_filter.sv
`timescale 1ns/1ps
// Synchronizer plus sliding-window majority vote, one per line.
module tw_glitch_filter #(
    parameter int LINES       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int WIN         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] clean
);
    localparam int CW = $clog2(WIN + 1);

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [SYNC_STAGES-1:0] sync_q;
            logic [WIN-1:0]         win_q;
            logic [CW-1:0]          ones;
            logic                   vote_q;

            always_comb begin
                ones = '0;
                for (int i = 0; i < WIN; i++) begin
                    ones = ones + CW'(win_q[i]);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '1;
                    win_q  <= '1;
                    vote_q <= 1'b1;
                end else begin
                    sync_q <= {sync_q[SYNC_STAGES-2:0], raw[g]};
                    win_q  <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
                    vote_q <= (ones > CW'(WIN / 2));
                end
            end

            assign clean[g] = vote_q;
        end
    endgenerate
endmodule

// File: rtl/tw_line_events.sv
`timescale 1ns/1ps
// Edge and bus-condition detection on the filtered lines.
module tw_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign bus_start = scl_f & scl_q & sda_q & ~sda_f;
    assign bus_stop  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/tw_mem_target.sv
`timescale 1ns/1ps
module tw_mem_target
    import tw_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2,
    parameter int FILTER_WIN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              busy_in,
    input  logic [7:0]        rd_data,
    output logic              sda_drive_low,
    output logic              addr_set,
    output logic [ADDR_W-1:0] word_addr,
    output logic              wr_strobe,
    output logic [7:0]        wr_data,
    output logic              rd_req,
    output logic              stop_evt
);
    logic [1:0] clean;
    logic       scl_f, sda_f;
    logic       scl_rise, scl_fall, ev_start, ev_stop;

    tw_glitch_filter #(
        .LINES      (2),
        .SYNC_STAGES(SYNC_STAGES),
        .WIN        (FILTER_WIN)
    ) u_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({scl_in, sda_in}),
        .clean(clean)
    );
    assign scl_f = clean[1];
    assign sda_f = clean[0];

    tw_line_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(ev_start),
        .bus_stop (ev_stop)
    );

    tw_state_e                st, nxt;
    logic [7:0]               sh;
    logic [CNT_W-1:0]         cnt;
    logic                     rw_q;
    logic [DEV_HI_W-1:0]      hi_q;
    logic [DEV_HI_W+7:0]      full_addr;
    logic                     byte_done;
    logic                     dev_ok;

    assign byte_done = scl_fall && (cnt == CNT_W'(BYTE_BITS));
    assign dev_ok    = (sh[7:4] == DEV_NIBBLE) && !busy_in;
    assign full_addr = {hi_q, sh};

    // Next-state selection
    always_comb begin
        nxt = st;
        if (ev_stop) begin
            nxt = ST_IDLE;
        end else if (ev_start) begin
            nxt = ST_DEV;
        end else begin
            unique case (st)
                ST_IDLE:      nxt = ST_IDLE;
                ST_DEV:       if (byte_done) nxt = dev_ok ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall)  nxt = rw_q ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_done) nxt = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall)  nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nxt = ST_WDATA;
                ST_RDATA:     if (byte_done) nxt = ST_RD_ACK;
                ST_RD_ACK:    if (scl_rise)  nxt = sda_f ? ST_WAIT_STOP : ST_RD_NEXT;
                ST_RD_NEXT:   if (scl_fall)  nxt = ST_RDATA;
                ST_WAIT_STOP: nxt = ST_WAIT_STOP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Shift path, drive and backend events
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh            <= '0;
            cnt           <= '0;
            rw_q          <= 1'b0;
            hi_q          <= '0;
            sda_drive_low <= 1'b0;
            addr_set      <= 1'b0;
            word_addr     <= '0;
            wr_strobe     <= 1'b0;
            wr_data       <= '0;
            rd_req        <= 1'b0;
            stop_evt      <= 1'b0;
        end else begin
            addr_set  <= 1'b0;
            wr_strobe <= 1'b0;
            rd_req    <= 1'b0;
            stop_evt  <= 1'b0;
            if (ev_stop) begin
                sda_drive_low <= 1'b0;
                stop_evt      <= 1'b1;
            end else if (ev_start) begin
                sda_drive_low <= 1'b0;
                cnt           <= '0;
            end else begin
                case (st)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            sh  <= {sh[6:0], sda_f};
                            cnt <= cnt + CNT_W'(1);
                        end
                        if (byte_done) begin
                            cnt <= '0;
                            if (st == ST_DEV) begin
                                if (dev_ok) begin
                                    sda_drive_low <= 1'b1;
                                    rw_q          <= sh[0];
                                    hi_q          <= sh[3:1];
                                    rd_req        <= sh[0];
                                end
                            end else if (st == ST_WADDR) begin
                                sda_drive_low <= 1'b1;
                                addr_set      <= 1'b1;
                                word_addr     <= full_addr[ADDR_W-1:0];
                            end else begin
                                sda_drive_low <= 1'b1;
                                wr_strobe     <= 1'b1;
                                wr_data       <= sh;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            if (st == ST_DEV_ACK && rw_q) begin
                                sh            <= rd_data;
                                sda_drive_low <= ~rd_data[7];
                                cnt           <= '0;
                            end else begin
                                sda_drive_low <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) cnt <= cnt + CNT_W'(1);
                        if (scl_fall) begin
                            if (cnt == CNT_W'(BYTE_BITS)) begin
                                sda_drive_low <= 1'b0;
                            end else begin
                                sh            <= {sh[6:0], 1'b0};
                                sda_drive_low <= ~sh[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise && !sda_f) rd_req <= 1'b1;
                    end
                    ST_RD_NEXT: begin
                        if (scl_fall) begin
                            sh            <= rd_data;
                            sda_drive_low <= ~rd_data[7];
                            cnt           <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tw_mem_target_chk.sv
`timescale 1ns/1ps
module tw_mem_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic drive,
    input logic busy_in,
    input logic dev_ack,
    input logic addr_set,
    input logic wr_strobe,
    input logic rd_req,
    input logic stop_evt
);
    assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(drive) |-> !$past(scl_f));

    assert_ack_with_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_set |-> drive);

    assert_ack_with_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> drive);

    assert_single_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_set, wr_strobe, rd_req, stop_evt}));

    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |-> !drive);

    assert_busy_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drive) && dev_ack) |-> !$past(busy_in));
endmodule

bind tw_mem_target tw_mem_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .drive    (sda_drive_low),
    .busy_in  (busy_in),
    .dev_ack  (st == tw_pkg::ST_DEV_ACK),
    .addr_set (addr_set),
    .wr_strobe(wr_strobe),
    .rd_req   (rd_req),
    .stop_evt (stop_evt)
);

// File: tb/tw_mem_target_bench.sv
`timescale 1ns/1ps
module tw_mem_target_bench;
    localparam int AW = 11;
    localparam int Q  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_h = 1'b1, sda_h = 1'b1, scl_glitch = 1'b0, busy = 1'b0;
    logic [7:0]    rd_data = 8'h00;
    logic          drv, addr_set, wr_strobe, rd_req, stop_evt;
    logic [AW-1:0] word_addr;
    logic [7:0]    wr_data;
    logic          sda_line, scl_line;

    assign sda_line = sda_h & ~drv;
    assign scl_line = scl_h ^ scl_glitch;

    always #2.5 clk = ~clk;

    tw_mem_target #(.ADDR_W(AW)) u_tw_mem_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .busy_in(busy), .rd_data(rd_data), .sda_drive_low(drv),
        .addr_set(addr_set), .word_addr(word_addr), .wr_strobe(wr_strobe),
        .wr_data(wr_data), .rd_req(rd_req), .stop_evt(stop_evt)
    );

    // Backend model: counter, page rollover on write, linear wrap on read
    logic [7:0]    mem [0:2047];
    logic [AW-1:0] bptr = '0;
    int n_wr = 0, n_addr = 0, n_rd = 0, n_stop = 0, n_viol = 0;
    logic [7:0]    last_wr = 8'h00;
    logic [AW-1:0] last_addr = '0;
    logic          drv_prev = 1'b0;

    always @(posedge clk) begin
        if (addr_set) begin bptr <= word_addr; last_addr <= word_addr; n_addr <= n_addr + 1; end
        if (wr_strobe) begin
            mem[bptr] <= wr_data; last_wr <= wr_data; n_wr <= n_wr + 1;
            bptr <= {bptr[AW-1:4], bptr[3:0] + 4'd1};
        end
        if (rd_req) begin rd_data <= mem[bptr]; bptr <= bptr + 1'b1; n_rd <= n_rd + 1; end
        if (stop_evt) n_stop <= n_stop + 1;
        if (rst_n && drv != drv_prev && scl_h) n_viol <= n_viol + 1;
        drv_prev <= drv;
    end

    // Expected contents and counter, computed from the requirements
    logic [7:0]    gold [0:2047];
    logic [AW-1:0] exp_ptr = '0;
    logic [7:0]    wbuf [0:31];
    int n_tests = 0, n_fail = 0;
    bit done = 0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q); scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(Q); scl_h = 1'b1; tick(Q); sda_h = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input bit b, input bit glitch);
        sda_h = b; tick(Q);
        if (glitch) begin scl_glitch = 1'b1; tick(1); scl_glitch = 1'b0; end
        scl_h = 1'b1; tick(Q); scl_h = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input int glitch_bit, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i], i == glitch_bit);
        sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q / 2);
        acked = !sda_line; tick(Q / 2); scl_h = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit host_ack, output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q / 2);
            b = {b[6:0], sda_line}; tick(Q / 2); scl_h = 1'b0;
        end
        tick(Q); sda_h = !host_ack; tick(Q); scl_h = 1'b1; tick(Q);
        scl_h = 1'b0; tick(Q); sda_h = 1'b1;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input int n, input int glitch_bit);
        bit ack; int w0;
        logic [AW-1:0] p;
        w0 = n_wr;
        bus_start();
        send_byte({4'hA, a[10:8], 1'b0}, -1, ack); chk("R2", "write dev ack", ack, 1);
        send_byte(a[7:0], -1, ack);                chk("R3", "word addr ack", ack, 1);
        chk("R3", "word_addr", last_addr, a);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], (k == 0) ? glitch_bit : -1, ack);
            chk("R4", "data ack", ack, 1);
            chk((glitch_bit >= 0) ? "R10" : "R4", "wr_data", last_wr, wbuf[k]);
            p = {a[10:4], a[3:0] + 4'(k)};
            gold[p] = wbuf[k];
        end
        exp_ptr = {a[10:4], a[3:0] + 4'(n)};
        bus_stop();
        chk("R4", "write strobes", n_wr - w0, n);
    endtask

    task automatic do_read(input bit random, input logic [AW-1:0] a, input int n);
        bit ack; logic [7:0] b; int r0;
        if (random) begin
            bus_start();
            send_byte({4'hA, a[10:8], 1'b0}, -1, ack); chk("R7", "dummy dev ack", ack, 1);
            send_byte(a[7:0], -1, ack);                chk("R7", "dummy addr ack", ack, 1);
            exp_ptr = a;
        end
        r0 = n_rd;
        bus_start();
        send_byte({4'hA, a[10:8], 1'b1}, -1, ack); chk("R5", "read dev ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(random ? "R7" : "R5", "read byte", b, gold[exp_ptr]);
            exp_ptr = exp_ptr + 1'b1;
        end
        bus_stop();
        chk("R5", "read requests", n_rd - r0, n);
    endtask

    initial begin
        bit ack; logic [7:0] b; int s0, w0, a0, r0;
        logic [AW-1:0] ra; int rn;
        for (int i = 0; i < 2048; i++) begin mem[i] = 8'h00; gold[i] = 8'h00; end
        void'($urandom(32'd20240611));
        tick(10); rst_n = 1'b1; tick(5);
        chk("R11", "drive after reset", drv, 0);
        chk("R11", "events after reset", n_wr + n_rd + n_addr + n_stop, 0);

        // R2: wrong nibble, then bytes ignored until START
        w0 = n_wr; a0 = n_addr;
        bus_start();
        send_byte(8'hB0, -1, ack); chk("R2", "bad nibble nack", ack, 0);
        send_byte(8'h10, -1, ack); chk("R2", "ignored byte nack", ack, 0);
        send_byte(8'h55, -1, ack); chk("R2", "ignored byte nack 2", ack, 0);
        bus_stop();
        chk("R2", "no backend events", (n_wr - w0) + (n_addr - a0), 0);

        // R3/R4 byte write with high bits from device address
        wbuf[0] = 8'h5A; s0 = n_stop;
        do_write(11'h123, 1, -1);
        chk("R1", "stop event", n_stop - s0, 1);

        // R4 page write of 18 bytes, rolls over inside page
        for (int k = 0; k < 18; k++) wbuf[k] = 8'(8'h30 + k * 7);
        do_write(11'h7FE, 18, -1);

        // R7 random read, R5 current-address read continues
        do_read(1'b1, 11'h7F0, 5);
        do_read(1'b0, 11'h000, 3);
        // R5 sequential read wrapping past the top of memory
        do_read(1'b1, 11'h7FE, 4);

        // R6 host NACK ends read
        bus_start();
        send_byte(8'hA2, -1, ack); send_byte(8'h23, -1, ack);
        bus_start();
        send_byte(8'hA3, -1, ack); chk("R6", "dev ack", ack, 1);
        r0 = n_rd;
        recv_byte(1'b0, b); chk("R6", "last byte", b, gold[11'h123]);
        recv_byte(1'b1, b); chk("R6", "released after nack", b, 8'hFF);
        chk("R6", "no request after nack", n_rd - r0, 0);
        bus_stop();

        // R9 busy refuses, then acknowledge polling succeeds
        busy = 1'b1;
        bus_start(); send_byte(8'hA0, -1, ack); bus_stop();
        chk("R9", "busy nack", ack, 0);
        busy = 1'b0;
        bus_start(); send_byte(8'hA0, -1, ack); bus_stop();
        chk("R9", "idle ack", ack, 1);

        // R1 START in the middle of a byte aborts it
        bus_start();
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
        wbuf[0] = 8'h3C;
        do_write(11'h055, 1, -1);
        do_read(1'b1, 11'h055, 1);

        // R10 one-cycle SCL glitch inside a data byte
        wbuf[0] = 8'hC3;
        do_write(11'h2A0, 1, 4);
        do_read(1'b1, 11'h2A0, 1);

        // Random writes and read-back
        for (int it = 0; it < 8; it++) begin
            ra = AW'($urandom % 2048);
            rn = 1 + int'($urandom % 4);
            for (int k = 0; k < rn; k++) wbuf[k] = 8'($urandom);
            do_write(ra, rn, -1);
            do_read(1'b1, ra, rn);
        end

        chk("R8", "drive moved while SCL high", n_viol, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule